// File: doc/BRIEF.md
# Packed Triangular Result Streamer

This block drains a lower-triangular matrix that an upstream solver has left in a packed store and delivers it as a stream of single elements over a valid/ready output. Storage is packed by rows: the element at (row, column) lives at address row·(row+1)/2 + column. Because the output walks rows from 0 upward, and within each row walks columns from 0 up to the diagonal, that order is the same as a plain linear walk of the store. The address therefore only needs to step by one per element.

The solver keeps each diagonal entry as the reciprocal of the value the consumer wants. This keeps a slow divide out of its own inner loop. The streamer undoes that on the way out: off-diagonal entries pass through unchanged, and each diagonal entry goes through a sequential fixed-point restoring divider that computes 1/x. Values are signed two's complement with FRAC fractional bits. A diagonal entry that is zero or negative, or whose reciprocal would not fit, gives the largest positive code.

A one-cycle `start` begins one matrix. `done` pulses once after the final element has been accepted. The store is read through a synchronous port with one cycle of read latency.

Top module: `packed_tri_streamer`

## Requirements
- R1: After `start`, the block asserts `rd_en` exactly once per element, at addresses 0, 1, 2, … TOTAL−1 in sequence, where TOTAL = N(N+1)/2. It never asserts `rd_en` at an address of TOTAL or above.
- R2: Each `start` accepted while idle produces exactly TOTAL accepted beats. The element order is row 0 to N−1, and within a row, column 0 up to that row.
- R3: An off-diagonal element (column < row) leaves on `out_data` bit-identical to the stored word.
- R4: A diagonal element with stored value x > 0 leaves as floor(2^(2·FRAC) / x). That result is clamped to 2^(DW−1)−1 when it exceeds that value.
- R5: A diagonal element whose stored value is zero or negative (sign bit set) leaves as 2^(DW−1)−1.
- R6: Count clock edges from the edge that samples `start`, or from the edge that accepts the previous beat. `out_valid` rises after 2 edges for an off-diagonal element and after 2·FRAC+4 edges for a diagonal element. It is low at all other times outside a beat.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` stays stable.
- R8: `done` is high for exactly one cycle, the cycle after the edge that accepts the last beat. The block is then idle.
- R9: `start` has no effect while a matrix is being streamed.
- R10: While reset is asserted, `out_valid`, `done` and `rd_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin streaming one matrix (sampled while idle) |
| rd_en | output | 1 | Read strobe into the packed store |
| rd_addr | output | ADDRW | Packed store address |
| rd_data | input | DW | Store read data, valid one cycle after `rd_en` |
| out_valid | output | 1 | Output element valid |
| out_ready | input | 1 | Consumer ready |
| out_data | output | DW | Output element |
| done | output | 1 | One-cycle pulse after the last beat is accepted |

## Verification
The bench builds the block with N=5, DW=16 and FRAC=8. That gives fifteen beats per matrix, five of them diagonal, with a 17-step divide on each diagonal. Q8.8 diagonal words reach the clamp boundary (x=1 gives 65536, which is clamped; x=2 gives exactly 32768, which is also clamped; x=3 gives 21845). The zero and negative codes are also covered. Four ready patterns, from always-ready to mostly-stalled, exercise holds on both diagonal and off-diagonal beats. A stray `start` in the middle of a matrix shows that it leaves both the beat count and the timing unchanged.

// File: rtl/tri_stream_pkg.sv
package tri_stream_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_LAND,
    ST_DIV,
    ST_SEND
  } st_e;

  function automatic int tri_count(input int n);
    return n * (n + 1) / 2;
  endfunction

endpackage

// File: rtl/tri_walk.sv
module tri_walk #(
  parameter int N     = 4,
  parameter int ADDRW = 4,
  parameter int IDXW  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             step,
  output logic [ADDRW-1:0] addr,
  output logic             is_diag,
  output logic             is_last
);

  localparam logic [IDXW-1:0] LAST_IDX = IDXW'(N - 1);

  logic [ADDRW-1:0] addr_q, addr_d;
  logic [IDXW-1:0]  row_q, row_d, col_q, col_d;

  always_comb begin
    addr_d = addr_q;
    row_d  = row_q;
    col_d  = col_q;
    if (clr) begin
      addr_d = '0;
      row_d  = '0;
      col_d  = '0;
    end else if (step) begin
      addr_d = addr_q + 1'b1;
      if (col_q == row_q) begin
        row_d = row_q + 1'b1;
        col_d = '0;
      end else begin
        col_d = col_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      row_q  <= '0;
      col_q  <= '0;
    end else if (clr || step) begin
      addr_q <= addr_d;
      row_q  <= row_d;
      col_q  <= col_d;
    end
  end

  assign addr    = addr_q;
  assign is_diag = (col_q == row_q);
  assign is_last = (row_q == LAST_IDX) && (col_q == LAST_IDX);

endmodule

// File: rtl/tri_recip.sv
module tri_recip #(
  parameter int DW   = 16,
  parameter int FRAC = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  output logic          busy,
  output logic [DW-1:0] result
);

  localparam int NUMW = 2 * FRAC + 1;
  localparam int QW   = (NUMW > DW) ? NUMW : DW;
  localparam int CW   = $clog2(NUMW + 1);
  localparam logic [QW-1:0]   MAXQ    = {{(QW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic [NUMW-1:0] NUM_ONE = {1'b1, {(NUMW-1){1'b0}}};
  localparam logic [CW-1:0]   STEPS   = CW'(NUMW);

  logic [DW-1:0]   dvs_q, dvs_d;
  logic [DW-1:0]   rem_q, rem_d;
  logic [NUMW-1:0] num_q, num_d;
  logic [QW-1:0]   quo_q, quo_d;
  logic [CW-1:0]   cnt_q, cnt_d;
  logic            sat_q, sat_d;
  logic            busy_q, busy_d;
  logic [DW:0]     trial;
  logic [DW-1:0]   sub;
  logic            ge;

  assign trial = {rem_q, num_q[NUMW-1]};
  assign ge    = (trial >= {1'b0, dvs_q});
  assign sub   = trial[DW-1:0] - dvs_q;

  always_comb begin
    dvs_d  = dvs_q;
    rem_d  = rem_q;
    num_d  = num_q;
    quo_d  = quo_q;
    cnt_d  = cnt_q;
    sat_d  = sat_q;
    busy_d = busy_q;
    if (load) begin
      dvs_d  = din;
      rem_d  = '0;
      num_d  = NUM_ONE;
      quo_d  = '0;
      cnt_d  = STEPS;
      sat_d  = din[DW-1] || (din == '0);
      busy_d = 1'b1;
    end else if (busy_q) begin
      rem_d = ge ? sub : trial[DW-1:0];
      num_d = {num_q[NUMW-2:0], 1'b0};
      quo_d = {quo_q[QW-2:0], ge};
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == CW'(1)) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (load || busy_q) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (load || busy_q) begin
      dvs_q <= dvs_d;
      rem_q <= rem_d;
      num_q <= num_d;
      quo_q <= quo_d;
      sat_q <= sat_d;
    end
  end

  assign busy   = busy_q;
  assign result = (sat_q || (quo_q > MAXQ)) ? MAXQ[DW-1:0] : quo_q[DW-1:0];

endmodule

// File: rtl/packed_tri_streamer.sv
module packed_tri_streamer #(
  parameter int N     = 4,
  parameter int DW    = 16,
  parameter int FRAC  = 8,
  parameter int TOTAL = N * (N + 1) / 2,
  parameter int ADDRW = $clog2(TOTAL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             rd_en,
  output logic [ADDRW-1:0] rd_addr,
  input  logic [DW-1:0]    rd_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [DW-1:0]    out_data,
  output logic             done
);

  import tri_stream_pkg::*;

  localparam int IDXW = $clog2(N + 1);

  st_e           st_q, st_d;
  logic [DW-1:0] out_q, out_d;
  logic          out_en;
  logic          done_q, done_d;
  logic          walk_clr, walk_step;
  logic          is_diag, is_last;
  logic          div_load, div_busy;
  logic [DW-1:0] div_res;

  tri_walk #(.N(N), .ADDRW(ADDRW), .IDXW(IDXW)) u_walk (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (walk_clr),
    .step    (walk_step),
    .addr    (rd_addr),
    .is_diag (is_diag),
    .is_last (is_last)
  );

  tri_recip #(.DW(DW), .FRAC(FRAC)) u_recip (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (div_load),
    .din    (rd_data),
    .busy   (div_busy),
    .result (div_res)
  );

  always_comb begin
    st_d      = st_q;
    out_d     = out_q;
    out_en    = 1'b0;
    done_d    = 1'b0;
    walk_clr  = 1'b0;
    walk_step = 1'b0;
    div_load  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          walk_clr = 1'b1;
          st_d     = ST_READ;
        end
      end
      ST_READ: st_d = ST_LAND;
      ST_LAND: begin
        if (is_diag) begin
          div_load = 1'b1;
          st_d     = ST_DIV;
        end else begin
          out_d  = rd_data;
          out_en = 1'b1;
          st_d   = ST_SEND;
        end
      end
      ST_DIV: begin
        if (!div_busy) begin
          out_d  = div_res;
          out_en = 1'b1;
          st_d   = ST_SEND;
        end
      end
      ST_SEND: begin
        if (out_ready) begin
          if (is_last) begin
            done_d = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            walk_step = 1'b1;
            st_d      = ST_READ;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk) begin
    if (out_en) out_q <= out_d;
  end

  assign rd_en     = (st_q == ST_READ);
  assign out_valid = (st_q == ST_SEND);
  assign out_data  = out_q;
  assign done      = done_q;

endmodule

// File: rtl/tri_stream_chk.sv
module tri_stream_chk #(
  parameter int DW    = 16,
  parameter int TOTAL = 10,
  parameter int ADDRW = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_en,
  input logic [ADDRW-1:0] rd_addr,
  input logic             out_valid,
  input logic             out_ready,
  input logic [DW-1:0]    out_data,
  input logic             done
);

  logic [ADDRW-1:0] prev_addr;
  logic             have_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_addr <= '0;
      have_prev <= 1'b0;
    end else if (rd_en) begin
      prev_addr <= rd_addr;
      have_prev <= 1'b1;
    end
  end

  AST_ADDR_LINEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && have_prev && rd_addr != '0) |-> (rd_addr == prev_addr + 1'b1)); // R1
  AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_addr < ADDRW'(TOTAL))); // R1
  AST_NO_READ_IN_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !rd_en); // R6
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid); // R7
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_data)); // R7
  AST_DONE_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(out_valid && out_ready)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !out_valid); // R8

endmodule

bind packed_tri_streamer tri_stream_chk #(.DW(DW), .TOTAL(TOTAL), .ADDRW(ADDRW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .done      (done)
);

// File: tb/tb_packed_tri_streamer.sv
`timescale 1ns/1ps
module tb_packed_tri_streamer;

  localparam int N     = 5;
  localparam int DW    = 16;
  localparam int FRAC  = 8;
  localparam int TOTAL = N * (N + 1) / 2;
  localparam int ADDRW = $clog2(TOTAL + 1);
  localparam int MAXP  = (1 << (DW - 1)) - 1;
  localparam int LAT_OFF  = 2;
  localparam int LAT_DIAG = 2 * FRAC + 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             rd_en;
  logic [ADDRW-1:0] rd_addr;
  logic [DW-1:0]    rd_data;
  logic             out_valid;
  logic             out_ready = 1'b0;
  logic [DW-1:0]    out_data;
  logic             done;

  always #2 clk = ~clk;

  packed_tri_streamer #(.N(N), .DW(DW), .FRAC(FRAC)) dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .done(done)
  );

  logic [DW-1:0] mem [TOTAL];
  int erow [TOTAL];
  int ecol [TOTAL];
  int vectors = 0;
  int errors  = 0;
  int cyc     = 0;
  int rmode   = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rd_en) rd_data <= (int'(rd_addr) < TOTAL) ? mem[rd_addr] : '0;
  end

  // ready patterns, driven away from the active edge
  always @(negedge clk) begin
    case (rmode)
      0: out_ready <= 1'b1;
      1: out_ready <= (cyc % 3) != 0;
      2: out_ready <= ((cyc >> 1) % 2) == (cyc % 2);
      default: out_ready <= (cyc % 7) < 2;
    endcase
  end

  function automatic logic [DW-1:0] expv(int i);
    int x, q;
    if (erow[i] != ecol[i]) return mem[i];
    x = int'($signed(mem[i]));
    if (x <= 0) return DW'(MAXP);
    q = (1 << (2 * FRAC)) / x;
    if (q > MAXP) q = MAXP;
    return DW'(q);
  endfunction

  function automatic int lat_of(int i);
    return (erow[i] == ecol[i]) ? LAT_DIAG : LAT_OFF;
  endfunction

  // behavioural reference model
  logic m_busy, m_valid, m_done, prev_stall;
  int   m_wait, m_idx, beats;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy <= 0; m_valid <= 0; m_done <= 0; m_wait <= 0; m_idx <= 0;
      prev_stall <= 0; beats <= 0;
    end else begin
      m_done     <= 0;
      prev_stall <= m_valid && !out_ready;
      if (!m_busy) begin
        if (start) begin
          m_busy <= 1; m_idx <= 0; m_valid <= 0; m_wait <= lat_of(0) - 1;
        end
      end else if (m_valid) begin
        if (out_ready) begin
          beats   <= beats + 1;
          m_valid <= 0;
          if (m_idx == TOTAL - 1) begin
            m_busy <= 0; m_done <= 1;
          end else begin
            m_idx  <= m_idx + 1;
            m_wait <= lat_of(m_idx + 1) - 1;
          end
        end
      end else if (m_wait == 0) begin
        m_valid <= 1;
      end else begin
        m_wait <= m_wait - 1;
      end
    end
  end

  task automatic fail(string req, string what, int act, int expct);
    errors++;
    $display("FAIL %s %s actual=%0h expected=%0h (t=%0t)", req, what, act, expct, $time);
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst_n) begin
      vectors++;
      if (out_valid || done || rd_en) fail("R10", "reset outputs", {out_valid, done, rd_en}, 0);
    end else begin
      vectors++;
      if (out_valid !== m_valid) fail("R6", "out_valid", out_valid, m_valid);
      if (done !== m_done) fail("R8", "done pulse", done, m_done);
      if (rd_en && int'(rd_addr) != m_idx) fail("R1", "rd_addr", rd_addr, m_idx);
      if (out_valid && m_valid && out_data !== expv(m_idx)) begin
        if (prev_stall) fail("R7", "held data", out_data, expv(m_idx));
        else if (erow[m_idx] != ecol[m_idx]) fail("R3", "off-diag data", out_data, expv(m_idx));
        else if ($signed(mem[m_idx]) <= 0) fail("R5", "saturated diag", out_data, expv(m_idx));
        else fail("R4", "reciprocal diag", out_data, expv(m_idx));
      end
      if (m_done) begin
        // R2 and R9: exactly TOTAL beats per matrix despite stray start pulses
        vectors++;
        if (beats != TOTAL) fail("R2", "beat count", beats, TOTAL);
      end
    end
  end

  always @(posedge clk) if (m_done) beats <= 0;

  task automatic fill(int p);
    for (int i = 0; i < TOTAL; i++) begin
      if (erow[i] == ecol[i]) mem[i] = DW'(256 + 37 * erow[i] + 11 * p);
      else mem[i] = DW'(p * 1000 + erow[i] * 77 - ecol[i] * 301);
    end
    if (p == 1) begin
      mem[0]  = 16'h0000;   // zero diag, R5
      mem[2]  = 16'hFF00;   // negative diag, R5
      mem[5]  = 16'h0001;   // clamp, R4
      mem[9]  = 16'h0003;   // 21845, R4
      mem[14] = 16'h0002;   // exactly 32768 -> clamp, R4
      mem[1]  = 16'h8000;   // off-diag passes unchanged, R3
      mem[13] = 16'h7FFF;
    end
  endtask

  task automatic run(int p, int mode, bit stray);
    int guard;
    fill(p);
    rmode = mode;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    guard = 0;
    while (!m_done && guard < 5000) begin
      @(negedge clk);
      guard++;
      if (stray && (guard == 30 || guard == 71)) start = 1'b1; // R9
      else start = 1'b0;
    end
    start = 1'b0;
    if (guard >= 5000) begin
      vectors++;
      fail("R8", "watchdog: no done", 0, 1);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    begin
      int k = 0;
      for (int r = 0; r < N; r++)
        for (int c = 0; c <= r; c++) begin
          erow[k] = r; ecol[k] = c; k++;
        end
    end
    rd_data = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run(0, 0, 1'b0);
    run(1, 1, 1'b1);
    run(2, 2, 1'b0);
    run(1, 3, 1'b1);
    run(3, 0, 1'b0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

endmodule